// File: doc/BRIEF.md
# Logarithm-to-Float Converter (Piecewise Linear)

The block takes a signed fixed-point base-2 logarithm and returns the single-precision floating-point number it stands for. The log word has 8 integer bits and 24 fraction bits in two's complement, so a value X = e + f, with f in [0,1), means 2^e times 2^f. The integer part e, plus the exponent bias, becomes the float exponent. The mantissa comes from a line a·f + b that approximates 2^f. The fraction range is split into 8 equal segments, and each segment has its own slope and intercept. The coefficients are derived at elaboration time from the parameters, so the block has no large exponential table.

A separate sign flag and zero flag go with the log word, because a logarithm can carry neither of them. The converter is a two-stage pipeline. It accepts a new word on every clock cycle, and a valid bit travels through the stages with the data. It sits behind log-domain multiply and divide datapaths, where a result has to go back to float before any addition.

Top module: `alog_pwl_conv`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly two clock cycles. The result for an input appears on `float_o` in the same cycle that its delayed valid appears.
- R2: A new input is accepted on every cycle, so back-to-back valid inputs produce back-to-back valid results in the same order.
- R3: For e in [-126, 127] with the zero flag low, bits [30:23] of `float_o` hold e + 127.
- R4: For a normal result, the value 1.m formed from mantissa bits [22:0] is within 0.08 % of 2^f, where f is bits [23:0] of `log_i` divided by 2^24.
- R5: Bit 31 of `float_o` equals `sign_i` for every valid input, including zero results.
- R6: When `zero_i` is high, `float_o` is a signed zero: bits [30:0] are all 0, whatever the log word holds.
- R7: When e (bits [31:24] of `log_i`, signed) is -127 or -128, the result is a signed zero: bits [30:0] are all 0.
- R8: While reset is asserted, and in the first cycle after reset, `valid_o` is 0 and `float_o` is 0.
- R9: When the fraction f is exactly 0, the mantissa bits [22:0] are 0, so an exact power of two converts exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word qualifier |
| log_i | input | 32 | Log value, 8.24 two's complement |
| sign_i | input | 1 | Sign of the value that is represented |
| zero_i | input | 1 | The value that is represented is zero |
| valid_o | output | 1 | Result qualifier, two cycles after the input |
| float_o | output | 32 | Single-precision result |

## Verification
Each of the eight segments has its own slope, intercept and offset correction. A wrong slope shows up as a growing mantissa error across that one segment. A wrong intercept shows up as a step at a segment boundary. Both appear two cycles after the first input that lands in the affected segment, and a sweep over every 12-bit fraction prefix reaches all of them. A fault in the exponent path, or in the special-case path, corrupts bits [31:23] two cycles after the input that triggers it. A fault in the valid pipeline shows up as a misaligned `valid_o` on the first gapped input pattern.

// File: rtl/alog_pkg.sv
package alog_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int EXP_MX = 254;
  localparam real LN2   = 0.6931471805599453;

  // secant slope of 2^f over segment k, scaled by 2^fw
  function automatic int seg_slope(input int k, input int segs, input int fw);
    real lo, hi;
    lo = 2.0 ** (real'(k) / real'(segs));
    hi = 2.0 ** (real'(k + 1) / real'(segs));
    return $rtoi((hi - lo) * real'(segs) * (2.0 ** real'(fw)) + 0.5);
  endfunction

  // segment start value, lowered by half the secant sag to balance the error
  function automatic int seg_base(input int k, input int segs, input int fw);
    real lo, sag;
    lo  = 2.0 ** (real'(k) / real'(segs));
    sag = LN2 * LN2 / (8.0 * real'(segs) * real'(segs)) *
          (2.0 ** ((real'(k) + 0.5) / real'(segs)));
    return $rtoi((lo - 0.5 * sag) * (2.0 ** real'(fw)) + 0.5);
  endfunction
endpackage

// File: rtl/alog_coef_rom.sv
module alog_coef_rom #(
  parameter int SEG_BITS = 3,
  parameter int FRAC_W   = 24,
  parameter int COEF_W   = 26
) (
  input  logic [SEG_BITS-1:0] seg_i,
  output logic [COEF_W-1:0]   slope_o,
  output logic [COEF_W-1:0]   base_o
);
  localparam int SEGS = 1 << SEG_BITS;

  logic [COEF_W-1:0] slope_tab [SEGS];
  logic [COEF_W-1:0] base_tab  [SEGS];

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    localparam logic [COEF_W-1:0] SLOPE = COEF_W'(alog_pkg::seg_slope(k, SEGS, FRAC_W));
    localparam logic [COEF_W-1:0] BASE  = COEF_W'(alog_pkg::seg_base(k, SEGS, FRAC_W));
    assign slope_tab[k] = SLOPE;
    assign base_tab[k]  = BASE;
  end

  assign slope_o = slope_tab[seg_i];
  assign base_o  = base_tab[seg_i];
endmodule

// File: rtl/alog_seg_eval.sv
module alog_seg_eval #(
  parameter int SEG_BITS = 3,
  parameter int FRAC_W   = 24,
  parameter int COEF_W   = 26
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W:0]   y_o      // Q1.FRAC_W, clamped to [1,2)
);
  localparam int DW = FRAC_W - SEG_BITS;
  localparam int PW = COEF_W + DW;
  localparam int YW = COEF_W + 1;

  logic [SEG_BITS-1:0] seg;
  logic [DW-1:0]       dlt;
  logic [COEF_W-1:0]   slope, base;
  logic [PW-1:0]       prod, prod_r;
  logic [YW-1:0]       y_raw;
  logic                unused_lsb;

  assign seg = frac_i[FRAC_W-1 -: SEG_BITS];
  assign dlt = frac_i[DW-1:0];

  alog_coef_rom #(
    .SEG_BITS(SEG_BITS), .FRAC_W(FRAC_W), .COEF_W(COEF_W)
  ) u_rom (
    .seg_i  (seg),
    .slope_o(slope),
    .base_o (base)
  );

  assign prod       = PW'(slope) * PW'(dlt);
  assign prod_r     = prod + (PW'(1) << (FRAC_W - 1));
  assign y_raw      = YW'(base) + YW'(prod_r[PW-1:FRAC_W]);
  assign unused_lsb = ^prod_r[FRAC_W-1:0];

  always_comb begin
    if (y_raw < (YW'(1) << FRAC_W))
      y_o = {1'b1, {FRAC_W{1'b0}}};
    else if (y_raw >= (YW'(2) << FRAC_W))
      y_o = '1;
    else
      y_o = y_raw[FRAC_W:0];
  end
endmodule

// File: rtl/alog_pack.sv
module alog_pack #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic [FRAC_W:0]         y_i,
  input  logic signed [INT_W-1:0] e_i,
  input  logic                    sign_i,
  input  logic                    zero_i,
  output logic [31:0]             flt_o
);
  import alog_pkg::*;
  localparam int BW = ((INT_W > 9) ? INT_W : 9) + 2;

  logic [MAN_W-1:0]    mant_hi;
  logic                rnd;
  logic [MAN_W:0]      mant_sum;
  logic signed [BW-1:0] biased;
  logic                unused_y;

  if (FRAC_W > MAN_W) begin : g_round
    assign mant_hi  = y_i[FRAC_W-1 -: MAN_W];
    assign rnd      = y_i[FRAC_W-MAN_W-1];
    assign unused_y = ^{y_i[FRAC_W], y_i[FRAC_W-MAN_W-1:0]};
  end else begin : g_pad
    assign mant_hi  = MAN_W'(y_i[FRAC_W-1:0]) << (MAN_W - FRAC_W);
    assign rnd      = 1'b0;
    assign unused_y = y_i[FRAC_W];
  end

  assign mant_sum = {1'b0, mant_hi} + (MAN_W+1)'(rnd);
  assign biased   = BW'(e_i) + BW'(BIAS) + BW'(mant_sum[MAN_W]);

  always_comb begin
    if (zero_i || biased < 1)
      flt_o = {sign_i, 31'b0};
    else if (biased > EXP_MX)
      flt_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else
      flt_o = {sign_i, biased[EXP_W-1:0], mant_sum[MAN_W-1:0]};
  end
endmodule

// File: rtl/alog_pwl_conv.sv
module alog_pwl_conv #(
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 24,
  parameter int SEG_BITS = 3,
  parameter int COEF_W   = FRAC_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [INT_W+FRAC_W-1:0]   log_i,
  input  logic                      sign_i,
  input  logic                      zero_i,
  output logic                      valid_o,
  output logic [31:0]               float_o
);
  localparam int LW = INT_W + FRAC_W;

  logic [FRAC_W:0] y_d;
  logic [FRAC_W:0] y_q;
  logic [INT_W-1:0] e_q;
  logic s_q, z_q, v_q;
  logic [31:0] flt_d;

  alog_seg_eval #(
    .SEG_BITS(SEG_BITS), .FRAC_W(FRAC_W), .COEF_W(COEF_W)
  ) u_eval (
    .frac_i(log_i[FRAC_W-1:0]),
    .y_o   (y_d)
  );

  // stage 1: segment evaluation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      y_q <= '0;
      e_q <= '0;
      s_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        y_q <= y_d;
        e_q <= log_i[LW-1 -: INT_W];
        s_q <= sign_i;
        z_q <= zero_i;
      end
    end
  end

  alog_pack #(
    .INT_W(INT_W), .FRAC_W(FRAC_W)
  ) u_pack (
    .y_i   (y_q),
    .e_i   ($signed(e_q)),
    .sign_i(s_q),
    .zero_i(z_q),
    .flt_o (flt_d)
  );

  // stage 2: rounding, exponent, specials
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      float_o <= '0;
    end else begin
      valid_o <= v_q;
      if (v_q) float_o <= flt_d;
    end
  end
endmodule

// File: rtl/alog_pwl_conv_chk.sv
module alog_pwl_conv_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [INT_W+FRAC_W-1:0] log_i,
  input logic                    sign_i,
  input logic                    zero_i,
  input logic                    valid_o,
  input logic [31:0]             float_o
);
  localparam int LW = INT_W + FRAC_W;
  localparam int BW = ((INT_W > 9) ? INT_W : 9) + 2;

  logic [1:0] arm_cnt;
  logic armed;
  logic signed [INT_W-1:0] e_in;
  logic signed [BW-1:0] exp_want;
  logic norm_in, under_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_cnt <= '0;
    else if (arm_cnt != 2'd2) arm_cnt <= arm_cnt + 2'd1;
  end
  assign armed    = (arm_cnt == 2'd2);
  assign e_in     = $signed(log_i[LW-1 -: INT_W]);
  assign exp_want = BW'(e_in) + BW'(127);
  assign norm_in  = valid_i && !zero_i && (exp_want >= 1);
  assign under_in = valid_i && !zero_i && (exp_want < 1);

  // R1
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i, 2));

  // R5
  sign_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(valid_i, 2) |-> float_o[31] == $past(sign_i, 2));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(valid_i && zero_i, 2) |-> float_o[30:0] == 31'b0);

  // R7
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(under_in, 2) |-> float_o[30:0] == 31'b0);

  // R3
  exp_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(norm_in, 2) |->
      (float_o[30:23] == $past(exp_want[7:0], 2)) ||
      (float_o[30:23] == $past(exp_want[7:0], 2) + 8'd1));
endmodule

bind alog_pwl_conv alog_pwl_conv_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .log_i(log_i),
  .sign_i(sign_i), .zero_i(zero_i), .valid_o(valid_o), .float_o(float_o)
);

// File: tb/alog_pwl_conv_bench.sv
`timescale 1ns/1ps
module alog_pwl_conv_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [31:0] log_i = '0;
  logic sign_i = 1'b0;
  logic zero_i = 1'b0;
  logic valid_o;
  logic [31:0] float_o;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  // bench-side two-cycle delay of the stimulus
  logic [34:0] d1 = '0, d2 = '0;

  always #5 clk_i = ~clk_i;

  alog_pwl_conv u_alog_pwl_conv (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .log_i(log_i),
    .sign_i(sign_i), .zero_i(zero_i), .valid_o(valid_o), .float_o(float_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      d1 <= '0; d2 <= '0;
    end else begin
      d1 <= {valid_i, sign_i, zero_i, log_i};
      d2 <= d1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (mon_on) begin
      // R1, R2: result valid lines up with the delayed input valid
      chk(valid_o == d2[34], "R1", {31'b0, valid_o}, {31'b0, d2[34]});
      if (d2[34]) begin
        automatic int e = $signed(d2[31:24]);
        automatic real f = real'(d2[23:0]) / 16777216.0;
        automatic logic s = d2[33];
        chk(float_o[31] == s, "R5", {31'b0, float_o[31]}, {31'b0, s});
        if (d2[32])
          chk(float_o[30:0] == 31'b0, "R6", float_o, {s, 31'b0});
        else if (e < -126)
          chk(float_o[30:0] == 31'b0, "R7", float_o, {s, 31'b0});
        else begin
          automatic real val = 1.0 + real'(float_o[22:0]) / 8388608.0;
          automatic real rel = val / (2.0 ** f) - 1.0;
          chk(int'(float_o[30:23]) == e + 127, "R3", {24'b0, float_o[30:23]}, 32'(e + 127));
          if (rel < 0.0) rel = -rel;
          if (rel > 0.0008) begin
            failures++;
            $display("FAIL R4 actual=%f expected=%f", val, 2.0 ** f);
          end
          checks++;
          if (d2[23:0] == 24'd0)
            chk(float_o[22:0] == 23'd0, "R9", {9'b0, float_o[22:0]}, 32'd0);
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [31:0] w, input logic s, input logic z);
    @(negedge clk_i);
    valid_i = v; log_i = w; sign_i = s; zero_i = z;
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    #(2_000_000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8: state during reset
    chk(valid_o == 1'b0 && float_o == 32'b0, "R8", float_o, 32'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 1'b0 && float_o == 32'b0, "R8", float_o, 32'b0);
    mon_on = 1'b1;

    // R2, R4: back-to-back sweep of every 12-bit fraction prefix at e = 0
    for (int i = 0; i < 4096; i++) begin
      lcg = next_rand(lcg);
      drive(1'b1, {8'd0, 12'(i), lcg[19:8]}, i[0], 1'b0);
    end
    // segment boundaries exactly and just below
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, {8'd3, 3'(k), 21'd0}, 1'b0, 1'b0);
      drive(1'b1, {8'd3, 3'(k), 21'h1F_FFFF}, 1'b1, 1'b0);
    end
    // R3, R7, R9: every exponent, with f = 0 and a random fraction
    for (int e = -128; e < 128; e++) begin
      lcg = next_rand(lcg);
      drive(1'b1, {8'(e), 24'd0}, lcg[31], 1'b0);
      drive(1'b1, {8'(e), lcg[27:4]}, lcg[30], 1'b0);
    end
    // R6: zero flag wins over any log word
    for (int i = 0; i < 64; i++) begin
      lcg = next_rand(lcg);
      drive(1'b1, lcg, i[0], 1'b1);
    end
    // R1: gapped valid, garbage on idle cycles
    for (int i = 0; i < 200; i++) begin
      lcg = next_rand(lcg);
      drive(lcg[13], {8'(lcg[7:0] % 100), lcg[31:8]}, lcg[14], lcg[15] & lcg[16]);
    end
    drive(1'b0, '0, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    mon_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule